// File: doc/BRIEF.md
# Two-Wire Serial Slave for a 256-Byte Memory

This block is the bus-facing end of a small byte-wide memory that a host reaches over a two-wire serial link. SCL and SDA arrive as plain inputs sampled by the core clock. The slave drives SDA through a single pull-down enable, and the wired-AND with the master is formed outside the block. The slave recognises START and STOP, matches its 7-bit device identity and the direction bit, and acknowledges the bytes it accepts. It keeps an internal address pointer that serves current-address, random and sequential reads.

Write data is collected in a page buffer whose slots correspond to the low address bits. The buffer is copied to the memory write port only when the master closes the transfer with STOP. While that commit and a programmable write time run, the slave stays silent on the bus, so a master can poll for completion by repeatedly sending the address. Memory reads are asynchronous: the block presents the pointer as the read address and takes the returned byte in the same cycle.

Top module: `twi_mem_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Any START received outside the write time restarts the byte framing at bit zero, even in the middle of a byte.
- R2: Only device byte 1010000 followed by the direction bit is acknowledged, sent MSB first. Direction 0 means write and 1 means read. After any other device byte the slave stays released until the next START, and the bytes that follow have no effect on the memory.
- R3: The slave pulls SDA low during the ninth clock of a matching device byte, of the word-address byte and of each write-data byte. The pull-down changes state only while SCL is low.
- R4: In a write, the byte after the device byte sets the pointer and the data bytes that follow reach the memory only after STOP.
- R5: Write data stays inside the aligned 8-byte page of the start address, and the offset wraps. Four bytes written from 06h land at 06h, 07h, 00h and 01h.
- R6: When more than 8 data bytes precede STOP, only the last 8 received are stored, each at its wrapped offset.
- R7: A START received where STOP was due discards the pending write data, and the memory is not changed.
- R8: For WR_CYCLES clock cycles after a committing STOP, the slave acknowledges nothing. After that time it acknowledges its address again.
- R9: A read with no preceding word address returns the byte at the pointer, which holds the last accessed address plus one.
- R10: A random read is a write of the device byte and word address, then a repeated START and a read. It returns the byte at that word address.
- R11: A sequential read continues while the master acknowledges, and the pointer wraps from FFh to 00h. A master NACK ends the read, and the slave then leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of master and slave) |
| sda_pd_o | output | 1 | Pull SDA low when 1 |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | 8 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_raddr_o | output | 8 | Memory read address (the internal pointer) |
| mem_rdata_i | input | 8 | Memory read data for mem_raddr_o, same cycle |

## Verification
Some properties are checked on every cycle:
- A START always restarts framing.
- The pull-down only changes in the SCL low phase.
- The slave never drives during its write time.
- The pointer stays in its page while write data streams in.
- A commit only starts after a STOP.

The scenarios are needed for the data itself: page wrap, which bytes survive a long write, an abort, polling during the write time, the pointer after each kind of read, and the read wrap at FFh. These appear only at the ports, as bytes read back over the bus.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RD,
    ST_WCYC
  } twi_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m1, scl_m2, scl_d;
  logic sda_m1, sda_m2, sda_d;

  // two-stage synchronisers plus one history stage, idle bus reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m1 <= 1'b1; scl_m2 <= 1'b1; scl_d <= 1'b1;
      sda_m1 <= 1'b1; sda_m2 <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m1 <= scl_i; scl_m2 <= scl_m1; scl_d <= scl_m2;
      sda_m1 <= sda_i; sda_m2 <= sda_m1; sda_d <= sda_m2;
    end
  end

  assign scl_o      = scl_m2;
  assign sda_o      = sda_m2;
  assign scl_rise_o = scl_m2 & ~scl_d;
  assign scl_fall_o = ~scl_m2 & scl_d;
  assign start_o    = scl_m2 & scl_d & ~sda_m2 & sda_d;
  assign stop_o     = scl_m2 & scl_d & sda_m2 & ~sda_d;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     put_i,
  input  logic [PAGE_W-1:0]        put_slot_i,
  input  logic [7:0]               put_data_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_i,
  input  logic                     go_i,
  output logic                     busy_o,
  output logic                     any_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_waddr_o,
  output logic [7:0]               mem_wdata_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [PAGE-1:0]   vld_q, vld_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  logic              busy_q, busy_d;
  logic [7:0]        dat_q [PAGE];

  always_comb begin
    vld_d  = vld_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    if (clr_i) vld_d = '0;
    if (put_i) vld_d[put_slot_i] = 1'b1;
    if (go_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = PAGE_W'(idx_q + 1'b1);
      if (idx_q == PAGE_W'(PAGE - 1)) begin
        busy_d = 1'b0;
        vld_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  // one data slot per page offset; a later byte to the same offset overwrites
  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (put_i && (put_slot_i == PAGE_W'(g))) dat_q[g] <= put_data_i;
    end
  end

  assign busy_o      = busy_q;
  assign any_o       = |vld_q;
  assign mem_we_o    = busy_q & vld_q[idx_q];
  assign mem_waddr_o = {base_i, idx_q};
  assign mem_wdata_o = dat_q[idx_q];

  // R4: a commit sweep only begins on a request from the controller
  assert_commit_on_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go_i));
  // R5: the page base stays fixed for the whole sweep
  assert_commit_one_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(base_i));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_W    = 3,
  parameter int         WR_CYCLES = 200,
  parameter logic [6:0] DEV_ID    = 7'b1010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [7:0]        mem_rdata_i
);
  import twi_pkg::*;

  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic buf_clr, buf_put, buf_go, buf_busy, buf_any;

  twi_state_t        st_q, st_d;
  logic [3:0]        bc_q, bc_d;
  logic [7:0]        sr_q, sr_d, tx_q, tx_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              pd_q, pd_d, mack_q, mack_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;

  twi_line_sync i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  twi_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_pbuf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .put_i(buf_put),
    .put_slot_i(ptr_q[PAGE_W-1:0]), .put_data_i(sr_q),
    .base_i(ptr_q[ADDR_W-1:PAGE_W]), .go_i(buf_go),
    .busy_o(buf_busy), .any_o(buf_any),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o)
  );

  always_comb begin
    st_d = st_q; bc_d = bc_q; sr_d = sr_q; tx_d = tx_q; ptr_d = ptr_q;
    pd_d = pd_q; mack_d = mack_q; tmr_d = tmr_q;
    buf_clr = 1'b0; buf_put = 1'b0; buf_go = 1'b0;
    if (st_q == ST_WCYC) begin
      // internal write time: the bus is ignored completely
      pd_d = 1'b0;
      if (tmr_q != '0) tmr_d = TMR_W'(tmr_q - 1'b1);
      else if (!buf_busy) st_d = ST_IDLE;
    end else if (start_p) begin
      st_d = ST_DEV; bc_d = '0; pd_d = 1'b0; buf_clr = 1'b1;
    end else if (stop_p) begin
      pd_d = 1'b0; bc_d = '0;
      if (st_q == ST_WDATA && buf_any) begin
        st_d = ST_WCYC; tmr_d = TMR_W'(WR_CYCLES - 1); buf_go = 1'b1;
      end else begin
        st_d = ST_IDLE;
      end
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bc_q < 4'd8) sr_d = {sr_q[6:0], sda_s};
        if (bc_q == 4'd8) mack_d = ~sda_s;   // ninth clock: acknowledge level
        if (bc_q != 4'd9) bc_d = 4'(bc_q + 1'b1);
      end else if (scl_fall) begin
        if (bc_q == 4'd8) begin
          case (st_q)
            ST_DEV: begin
              if (sr_q[7:1] == DEV_ID) begin
                pd_d = 1'b1;
                st_d = sr_q[0] ? ST_RD : ST_WADDR;
              end else begin
                st_d = ST_IDLE;
              end
            end
            ST_WADDR: begin
              pd_d = 1'b1; ptr_d = sr_q[ADDR_W-1:0]; st_d = ST_WDATA;
            end
            ST_WDATA: begin
              pd_d = 1'b1; buf_put = 1'b1;
              ptr_d = {ptr_q[ADDR_W-1:PAGE_W], PAGE_W'(ptr_q[PAGE_W-1:0] + 1'b1)};
            end
            default: pd_d = 1'b0;
          endcase
        end else if (bc_q == 4'd9) begin
          bc_d = '0; pd_d = 1'b0;
          if (st_q == ST_RD) begin
            if (mack_q) begin
              pd_d  = ~mem_rdata_i[7];
              tx_d  = {mem_rdata_i[6:0], 1'b0};
              ptr_d = ADDR_W'(ptr_q + 1'b1);
            end else begin
              st_d = ST_IDLE;
            end
          end
        end else if (st_q == ST_RD && bc_q != 4'd0) begin
          pd_d = ~tx_q[7];
          tx_d = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bc_q <= '0; sr_q <= '0; tx_q <= '0; ptr_q <= '0;
      pd_q <= 1'b0; mack_q <= 1'b0; tmr_q <= '0;
    end else begin
      st_q <= st_d; bc_q <= bc_d; sr_q <= sr_d; tx_q <= tx_d; ptr_q <= ptr_d;
      pd_q <= pd_d; mack_q <= mack_d; tmr_q <= tmr_d;
    end
  end

  assign sda_pd_o    = pd_q;
  assign mem_raddr_o = ptr_q;

  // R1: a START outside the write time restarts framing at bit zero
  assert_start_resync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && st_q != ST_WCYC) |=> (bc_q == 4'd0 && st_q == ST_DEV));
  // R3: the pull-down only moves while SCL is low (bus conditions excepted)
  assert_pd_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pd_o != $past(sda_pd_o)) |-> (!$past(scl_s) || $past(start_p) || $past(stop_p)));
  // R8: silent during the internal write time
  assert_quiet_write_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WCYC && $past(st_q == ST_WCYC)) |-> !sda_pd_o);
  // R5: streaming write data never leaves its page
  assert_ptr_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDATA && $past(st_q == ST_WDATA)) |->
      (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int WRC = 200;
  localparam int Q   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_pd, we;
  logic [7:0] waddr, wdata, raddr, rdata;
  wire  sda_line = sda_m & ~sda_pd;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [8];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  twi_mem_slave i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pd_o(sda_pd),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .mem_raddr_o(raddr), .mem_rdata_i(rdata)
  );

  always @(posedge clk) if (we) mem[waddr] <= wdata;
  assign rdata = mem[raddr];

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0;
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic bit_out(logic b);
    wt(Q); sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0;
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(2*Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0;
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask
  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(nack);
  endtask

  // write transaction with wbuf[0..n-1]; the model follows page wrap and last-8 rules
  task automatic wr_txn(input logic [7:0] a, input int n, input string req);
    logic ack;
    bus_start;
    wr_byte(8'hA0, ack); chk({req, " device ack"}, ack, 1);
    wr_byte(a, ack);     chk({req, " word ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], ack);
      chk({req, " data ack"}, ack, 1);
      expm[{a[7:3], 3'(a[2:0] + k)}] = wbuf[k];
    end
    bus_stop;
    wt(WRC + 40);
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n);
    logic ack;
    bus_start;
    wr_byte(8'hA0, ack); chk("R10 dummy device ack", ack, 1);
    wr_byte(a, ack);     chk("R10 dummy word ack", ack, 1);
    bus_start;
    wr_byte(8'hA1, ack); chk("R10 read device ack", ack, 1);
    for (int k = 0; k < n; k++) rd_byte(k == n - 1, rbuf[k]);
    bus_stop;
    wt(2*Q);
  endtask

  task automatic rd_cur(input int n);
    logic ack;
    bus_start;
    wr_byte(8'hA1, ack); chk("R9 device ack", ack, 1);
    for (int k = 0; k < n; k++) rd_byte(k == n - 1, rbuf[k]);
    bus_stop;
    wt(2*Q);
  endtask

  task automatic t_reset;
    chk("R3 pull-down released after reset", sda_pd, 0);
    chk("R4 no write strobe after reset", we, 0);
  endtask

  task automatic t_byte_write;
    wbuf[0] = 8'h3C;
    wr_txn(8'h20, 1, "R3");
    rd_rand(8'h20, 1);
    chk("R4 byte write stored", rbuf[0], 8'h3C);
    rd_cur(1);
    chk("R9 current address is last plus one", rbuf[0], expm[8'h21]);
  endtask

  task automatic t_poll;
    logic ack;
    bus_start; wr_byte(8'hA0, ack); wr_byte(8'h28, ack); wr_byte(8'h5A, ack);
    expm[8'h28] = 8'h5A;
    bus_stop;
    bus_start; wr_byte(8'hA0, ack);
    chk("R8 no ack during write time", ack, 0);
    bus_stop;
    wt(WRC + 40);
    bus_start; wr_byte(8'hA0, ack);
    chk("R8 ack after write time", ack, 1);
    bus_stop;
    wt(2*Q);
    rd_rand(8'h28, 1);
    chk("R8 polled write stored", rbuf[0], 8'h5A);
  endtask

  task automatic t_page_wrap;
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hE0 + k);
    wr_txn(8'h06, 4, "R5");
    rd_rand(8'h00, 8);
    for (int k = 0; k < 8; k++) chk($sformatf("R5 page byte %0d", k), rbuf[k], expm[k]);
    chk("R5 wrapped byte at 00h", rbuf[0], 8'hE2);
    chk("R5 wrapped byte at 07h", rbuf[7], 8'hE1);
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'hD0 + k);
    wr_txn(8'h40, 10, "R6");
    rd_rand(8'h40, 8);
    chk("R6 slot 0 holds ninth byte", rbuf[0], 8'hD8);
    chk("R6 slot 1 holds tenth byte", rbuf[1], 8'hD9);
    chk("R6 slot 2 holds third byte", rbuf[2], 8'hD2);
    chk("R6 slot 7 holds eighth byte", rbuf[7], 8'hD7);
  endtask

  task automatic t_abort;
    logic ack;
    bus_start; wr_byte(8'hA0, ack); wr_byte(8'h50, ack); wr_byte(8'h77, ack);
    wr_byte(8'h78, ack);
    bus_start;   // replaces STOP
    bus_stop;
    wt(20);
    bus_start; wr_byte(8'hA0, ack);
    chk("R7 no write time after abort", ack, 1);
    bus_stop; wt(2*Q);
    rd_rand(8'h50, 2);
    chk("R7 aborted byte discarded", rbuf[0], expm[8'h50]);
    chk("R7 aborted second byte discarded", rbuf[1], expm[8'h51]);
  endtask

  task automatic t_bad_addr;
    logic ack;
    bus_start;
    wr_byte(8'hA2, ack); chk("R2 foreign device byte not acked", ack, 0);
    wr_byte(8'h60, ack); chk("R2 following byte not acked", ack, 0);
    wr_byte(8'h11, ack);
    bus_stop;
    wt(WRC + 40);
    rd_rand(8'h60, 1);
    chk("R2 memory untouched by foreign write", rbuf[0], expm[8'h60]);
  endtask

  task automatic t_seq_wrap;
    rd_rand(8'hFE, 3);
    chk("R11 byte FEh", rbuf[0], expm[8'hFE]);
    chk("R11 byte FFh", rbuf[1], expm[8'hFF]);
    chk("R11 wrap to 00h", rbuf[2], expm[8'h00]);
    chk("R11 SDA released after NACK and STOP", sda_line, 1);
    rd_cur(1);
    chk("R9 pointer after wrap", rbuf[0], expm[8'h01]);
  endtask

  task automatic t_resync;
    bus_start;
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    wbuf[0] = 8'h99;
    wr_txn(8'h30, 1, "R1");
    rd_rand(8'h30, 1);
    chk("R1 write after mid-byte START", rbuf[0], 8'h99);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 7 + 3);
      expm[i] = 8'(i * 7 + 3);
    end
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    wt(5); rst_n = 1'b1; wt(5);
    t_reset;
    t_byte_write;
    t_poll;
    t_page_wrap;
    t_overflow;
    t_abort;
    t_bad_addr;
    t_seq_wrap;
    t_resync;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule